// File: doc/BRIEF.md
# Trigger-Selectable One-Shot Timer Waveform Generator

This block holds one 16-bit down-counter that drives a single waveform output. A three-bit mode code chooses which event starts the count. The choices are a high level on the external trigger input, a rising edge of that input, either edge of that input, or either edge of a companion PWM signal. On every accepted trigger the counter loads the programmed reload value and starts again. The output stays high while the count runs. When the count ends, an underflow flag is set. That flag drives the interrupt output when the interrupt enable bit is 1.

Software sets up the block through a small write-only register port, with writes taking effect at the clock edge where `wr_en` is high:
- Address 0 is the control word: bits [2:0] hold the mode, bit 3 the interrupt enable, and bits [5:4] the clock-divider select.
- Address 1 holds the reload value.
- Address 2 clears the flag when bit 0 of the written data is 1.
- Address 3 has no effect.

The counter decrements once per divided clock tick. The divider select values 0, 1, 2 and 3 give a tick every 1, 2, 4 or 8 clocks.

Top module: `trig_wavegen`

## Requirements
- R1: After reset, `wave_out`, `irq` and `tmr_flag` are 0 and the timer is idle.
- R2: Mode 3'b001 (level): each cycle with `trig_in` high reloads the counter. The count runs down only after `trig_in` returns low. With divider 1, a high level lasting H cycles gives an output pulse of H + reload cycles.
- R3: Mode 3'b010 (rising edge): a 0-to-1 change of `trig_in` starts a pulse. A falling edge, or a level held high, does not start one.
- R4: Mode 3'b100 (both edges): either edge of `trig_in` starts a pulse.
- R5: Mode 3'b111 (companion): either edge of `pwm_in` starts a pulse, and `trig_in` has no effect.
- R6: Any other mode code keeps the timer idle with `wave_out` low and no trigger accepted. Writing such a code while a count runs stops it without setting the flag.
- R7: After a trigger with no later trigger, `wave_out` is high for exactly (reload+1) × divider clock cycles. A reload of 0 gives one divider period.
- R8: A trigger accepted while the counter runs reloads it and restarts the full pulse length from that trigger.
- R9: A reload value written while counting does not change the running count. The next trigger loads it.
- R10: `tmr_flag` is set at underflow and stays set until a write to address 2 with data bit 0 equal to 1. If an underflow and a clear fall in the same cycle, the flag is set.
- R11: `irq` is high exactly when `tmr_flag` is 1 and the interrupt enable bit is 1.
- R12: Divider select codes 0 to 3 give divisors 1, 2, 4 and 8. A control write made while the counter runs leaves the divider select unchanged.
- R13: A mode write takes effect in the cycle after the write edge: `wave_out` reflects the new mode immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 reload, 2 flag clear) |
| wr_data | input | 16 | Register write data |
| trig_in | input | 1 | External trigger input |
| pwm_in | input | 1 | Companion PWM signal used as a trigger in mode 3'b111 |
| wave_out | output | 1 | Waveform output, high while the count runs |
| tmr_flag | output | 1 | Underflow flag |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
The assertions watch several rules on every cycle:
- Every accepted trigger loads the reload value.
- The count holds between divider ticks.
- An underflow always raises the flag, and the flag holds until it is cleared.
- An unsupported mode stops the counter.
- A rising-edge trigger never fires on two consecutive cycles.
- A control write made while running leaves the divider untouched.

Only the bench scenarios can show the exact pulse lengths across modes, divisors, retriggers and level-held triggers. They are also the only check that a reload written mid-count waits for the next trigger, and that the flag wins a same-cycle set and clear.

// File: rtl/tw_pkg.sv
// Package: shared constants and helpers for the trigger-selectable timer.
// Assumes: the mode field is 3 bits wide and the register address is 2 bits wide.
package tw_pkg;
    localparam int MODE_W = 3;
    localparam int ADDR_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_LEVEL = 3'b001,
        MODE_RISE  = 3'b010,
        MODE_BOTH  = 3'b100,
        MODE_COMP  = 3'b111
    } trig_mode_e;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CLEAR  = 2'd2;

    // Returns 1 when the mode code names one of the four supported trigger sources.
    function automatic logic mode_supported(input logic [MODE_W-1:0] m);
        return (m == MODE_LEVEL) || (m == MODE_RISE) ||
               (m == MODE_BOTH)  || (m == MODE_COMP);
    endfunction
endpackage

// File: rtl/tw_regs.sv
// Module: register file. It holds the mode, the interrupt enable, the divider select
// and the reload value, and it produces a one-cycle flag-clear pulse.
// Assumes: writes take effect at the clock edge where wr_en is high.
// The divider select is frozen while the counter runs (busy = 1).
module tw_regs
    import tw_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              busy,
    output logic [MODE_W-1:0] mode,
    output logic              irq_en,
    output logic [SEL_W-1:0]  div_sel,
    output logic [CNT_W-1:0]  reload,
    output logic              clr_flag
);
    localparam int IE_BIT  = MODE_W;
    localparam int SEL_LSB = MODE_W + 1;

    logic wr_ctrl;
    logic wr_reload;

    // Decode which register the current write targets.
    always_comb begin
        wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
        wr_reload = wr_en && (wr_addr == ADDR_RELOAD);
        clr_flag  = wr_en && (wr_addr == ADDR_CLEAR) && wr_data[0];
    end

    // Mode and interrupt enable: written at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= '0;
            irq_en <= 1'b0;
        end else if (wr_ctrl) begin
            mode   <= wr_data[MODE_W-1:0];
            irq_en <= wr_data[IE_BIT];
        end
    end

    // Divider select: only updated while the counter is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_sel <= '0;
        else if (wr_ctrl && !busy)
            div_sel <= wr_data[SEL_LSB +: SEL_W];
    end

    // Reload value: held here until the next trigger copies it into the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload <= '0;
        else if (wr_reload)
            reload <= wr_data;
    end

    // R12
    div_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && busy) |=> $stable(div_sel));
endmodule

// File: rtl/tw_trig.sv
// Module: trigger detector. It compares each input with its value on the previous
// cycle and asserts hit when the condition chosen by the mode is met.
// Assumes: the inputs are already synchronous to clk. An unsupported mode never hits.
module tw_trig
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              trig_in,
    input  logic              pwm_in,
    output logic              hit
);
    logic trig_q;
    logic pwm_q;

    // Store the previous input levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            pwm_q  <= 1'b0;
        end else begin
            trig_q <= trig_in;
            pwm_q  <= pwm_in;
        end
    end

    // Choose the trigger condition from the mode.
    always_comb begin
        unique case (mode)
            MODE_LEVEL: hit = trig_in;
            MODE_RISE:  hit = trig_in && !trig_q;
            MODE_BOTH:  hit = trig_in ^ trig_q;
            MODE_COMP:  hit = pwm_in ^ pwm_q;
            default:    hit = 1'b0;
        endcase
    end

    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RISE && hit) |=> (mode != MODE_RISE || !hit));
endmodule

// File: rtl/tw_prescale.sv
// Module: clock divider. While the timer runs it emits one tick every
// 2**div_sel cycles, counted from the latest trigger.
// Assumes: div_sel does not change while run is high.
module tw_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int PCNT_W = (1 << SEL_W) - 1;

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] lim;

    // Terminal count for the selected divisor.
    always_comb begin
        lim  = PCNT_W'((32'd1 << div_sel) - 32'd1);
        tick = run && !restart && (pcnt == lim);
    end

    // Divider count: restarts on a trigger or when idle, and wraps at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart || pcnt == lim)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/tw_core.sv
// Module: down-counter, run state and underflow flag. A trigger loads the reload
// value and starts the count. Each tick decrements it, and a tick at zero ends the
// run and sets the flag.
// Assumes: hit only rises in a supported mode. An unsupported mode forces idle.
module tw_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ok,
    input  logic             hit,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    input  logic             clr_flag,
    output logic             running,
    output logic             flag
);
    logic [CNT_W-1:0] cnt;
    logic             under;

    // Underflow happens when a tick arrives with the count already at zero.
    always_comb begin
        under = mode_ok && running && !hit && tick && (cnt == '0);
    end

    // Counter and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (!mode_ok) begin
            running <= 1'b0;
        end else if (hit) begin
            cnt     <= reload;
            running <= 1'b1;
        end else if (running && tick) begin
            if (cnt == '0)
                running <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    // Underflow flag: setting wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (under)
            flag <= 1'b1;
        else if (clr_flag)
            flag <= 1'b0;
    end

    // R8
    reload_on_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ok && hit) |=> (running && cnt == $past(reload)));
    // R7
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ok && running && !hit && !tick) |=> $stable(cnt));
    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ok && running && !hit && tick && cnt == '0) |=> flag);
    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_flag) |=> flag);
    // R6
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |=> !running);
endmodule

// File: rtl/trig_wavegen.sv
// Module: top of the trigger-selectable timer waveform generator. It connects the
// register file, the trigger detector, the divider and the counter core.
// Assumes: all inputs are synchronous to clk. The reset is synchronous and active-low.
module trig_wavegen
    import tw_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              trig_in,
    input  logic              pwm_in,
    output logic              wave_out,
    output logic              tmr_flag,
    output logic              irq
);
    logic [MODE_W-1:0] mode;
    logic              irq_en;
    logic [SEL_W-1:0]  div_sel;
    logic [CNT_W-1:0]  reload;
    logic              clr_flag;
    logic              hit;
    logic              tick;
    logic              running;
    logic              mode_ok;

    // Decide whether the current mode code is supported.
    always_comb mode_ok = mode_supported(mode);

    tw_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(running), .mode(mode), .irq_en(irq_en),
        .div_sel(div_sel), .reload(reload), .clr_flag(clr_flag)
    );

    tw_trig u_trig (
        .clk(clk), .rst_n(rst_n), .mode(mode), .trig_in(trig_in),
        .pwm_in(pwm_in), .hit(hit)
    );

    tw_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(running), .restart(hit),
        .div_sel(div_sel), .tick(tick)
    );

    tw_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .mode_ok(mode_ok), .hit(hit), .tick(tick),
        .reload(reload), .clr_flag(clr_flag), .running(running), .flag(tmr_flag)
    );

    // Drive the outputs: the wave follows the run state in a supported mode.
    always_comb begin
        wave_out = running && mode_ok;
        irq      = tmr_flag && irq_en;
    end
endmodule

// File: tb/tb_trig_wavegen.sv
module tb_trig_wavegen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        trig_in = 1'b0;
    logic        pwm_in = 1'b0;
    logic        wave_out, tmr_flag, irq;

    int checks = 0;
    int errors = 0;

    trig_wavegen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_in(trig_in), .pwm_in(pwm_in),
        .wave_out(wave_out), .tmr_flag(tmr_flag), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Tasks start and end on a falling edge.
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] ctrl(input int mode, input int ie, input int div);
        return 16'(mode | (ie << 3) | (div << 4));
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count the consecutive high samples that follow the current edge.
    task automatic pulse(output int n);
        n = 0;
        @(negedge clk);
        while (wave_out && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic window(input int cyc, output int n);
        n = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (wave_out) n++;
        end
    endtask

    task automatic t_reset();
        chk("R1 wave after reset", wave_out, 0);
        chk("R1 flag after reset", tmr_flag, 0);
        chk("R1 irq after reset", irq, 0);
    endtask

    task automatic t_level();
        int n;
        wr(2'd0, ctrl(1, 0, 0)); wr(2'd1, 16'd5);
        trig_in = 1'b1; n = 0;
        for (int i = 1; i < 100; i++) begin
            @(negedge clk);
            if (wave_out) n++; else break;
            if (i == 4) trig_in = 1'b0;
        end
        chk("R2 level pulse H+reload", n, 9);
        idle(3);
    endtask

    task automatic t_rise();
        int n;
        wr(2'd0, ctrl(2, 0, 0)); wr(2'd1, 16'd5);
        trig_in = 1'b1; pulse(n);
        chk("R3 R7 rising pulse", n, 6);
        window(5, n);
        chk("R3 held level no retrigger", n, 0);
        trig_in = 1'b0; window(10, n);
        chk("R3 falling edge ignored", n, 0);
    endtask

    task automatic t_both();
        int n;
        wr(2'd0, ctrl(4, 0, 0)); wr(2'd1, 16'd5);
        trig_in = 1'b1; pulse(n);
        chk("R4 rising edge pulse", n, 6);
        trig_in = 1'b0; pulse(n);
        chk("R4 falling edge pulse", n, 6);
    endtask

    task automatic t_comp();
        int n;
        wr(2'd0, ctrl(7, 0, 0)); wr(2'd1, 16'd5);
        trig_in = 1'b1; window(4, n);
        trig_in = 1'b0; window(6, n);
        chk("R5 trig_in ignored in companion mode", n, 0);
        pwm_in = 1'b1; pulse(n);
        chk("R5 pwm rising pulse", n, 6);
        pwm_in = 1'b0; pulse(n);
        chk("R5 pwm falling pulse", n, 6);
    endtask

    task automatic t_invalid();
        int n;
        wr(2'd0, ctrl(3, 0, 0));
        trig_in = 1'b1; pwm_in = 1'b1; window(4, n);
        trig_in = 1'b0; pwm_in = 1'b0; window(6, n);
        chk("R6 code 011 idle", n, 0);
        wr(2'd0, ctrl(0, 0, 0));
        trig_in = 1'b1; window(4, n);
        trig_in = 1'b0; window(6, n);
        chk("R6 code 000 idle", n, 0);
    endtask

    task automatic t_stop();
        wr(2'd2, 16'd1);
        wr(2'd0, ctrl(4, 0, 0)); wr(2'd1, 16'd20);
        trig_in = 1'b1;
        for (int i = 1; i <= 3; i++) @(negedge clk);
        chk("R7 running before stop", wave_out, 1);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = ctrl(3, 0, 0);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R13 R6 wave low one cycle after mode write", wave_out, 0);
        trig_in = 1'b0; idle(30);
        chk("R6 stopped count sets no flag", tmr_flag, 0);
        chk("R6 still idle", wave_out, 0);
    endtask

    task automatic t_zero();
        int n;
        wr(2'd0, ctrl(2, 0, 0)); wr(2'd1, 16'd0);
        trig_in = 1'b1; pulse(n);
        chk("R7 reload zero one period", n, 1);
        trig_in = 1'b0; idle(2);
    endtask

    task automatic t_retrig();
        int n;
        wr(2'd0, ctrl(4, 0, 0)); wr(2'd1, 16'd10);
        trig_in = 1'b1; n = 0;
        for (int i = 1; i < 100; i++) begin
            @(negedge clk);
            if (wave_out) n++; else break;
            if (i == 4) trig_in = 1'b0;
        end
        chk("R8 retrigger restarts count", n, 15);
    endtask

    task automatic t_reload_hold();
        int n;
        wr(2'd0, ctrl(4, 0, 0)); wr(2'd1, 16'd10);
        trig_in = 1'b1; n = 0;
        for (int i = 1; i < 100; i++) begin
            @(negedge clk);
            if (wave_out) n++; else break;
            if (i == 3) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd3; end
            if (i == 4) wr_en = 1'b0;
        end
        chk("R9 mid-count reload ignored", n, 11);
        trig_in = 1'b0; pulse(n);
        chk("R9 new reload used at next trigger", n, 4);
    endtask

    task automatic t_div();
        int n;
        wr(2'd0, ctrl(2, 0, 2)); wr(2'd1, 16'd2);
        trig_in = 1'b1; pulse(n);
        chk("R12 divide by 4", n, 12);
        trig_in = 1'b0; idle(2);
        wr(2'd0, ctrl(2, 0, 3)); wr(2'd1, 16'd1);
        trig_in = 1'b1; pulse(n);
        chk("R12 divide by 8", n, 16);
        trig_in = 1'b0; idle(2);
        wr(2'd0, ctrl(2, 0, 1)); wr(2'd1, 16'd2);
        trig_in = 1'b1; n = 0;
        for (int i = 1; i < 100; i++) begin
            @(negedge clk);
            if (wave_out) n++; else break;
            if (i == 2) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = ctrl(2, 0, 0); end
            if (i == 3) wr_en = 1'b0;
        end
        chk("R12 divide by 2 with write while running", n, 6);
        trig_in = 1'b0; idle(2);
        trig_in = 1'b1; pulse(n);
        chk("R12 divider unchanged by write while running", n, 6);
        trig_in = 1'b0; idle(2);
    endtask

    task automatic t_flag();
        int n;
        wr(2'd2, 16'd1);
        chk("R10 flag cleared", tmr_flag, 0);
        wr(2'd0, ctrl(2, 0, 0)); wr(2'd1, 16'd2);
        trig_in = 1'b1; pulse(n);
        chk("R10 flag set at underflow", tmr_flag, 1);
        chk("R11 irq masked", irq, 0);
        idle(5);
        chk("R10 flag stays set", tmr_flag, 1);
        wr(2'd2, 16'd0);
        chk("R10 clear with bit0=0 has no effect", tmr_flag, 1);
        wr(2'd0, ctrl(2, 1, 0));
        chk("R11 irq when enabled", irq, 1);
        wr(2'd2, 16'd1);
        chk("R10 flag cleared by write", tmr_flag, 0);
        chk("R11 irq drops with flag", irq, 0);
        trig_in = 1'b0; idle(2);
        wr(2'd1, 16'd0);
        trig_in = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10 set wins over same-cycle clear", tmr_flag, 1);
        chk("R11 irq on set", irq, 1);
        trig_in = 1'b0; idle(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level();
        t_rise();
        t_both();
        t_comp();
        t_invalid();
        t_stop();
        t_zero();
        t_retrig();
        t_reload_hold();
        t_div();
        t_flag();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule